// File: doc/BRIEF.md
# Configuration Frame Readback Sequencer

This block drives a 32-bit configuration access port through the fixed command sequence that reads a run of configuration frames back out of the device. A one-cycle start request, together with a frame count, launches the sequence. The sequencer writes a synchronization word, the read-configuration command, the starting frame address and a read packet header. It then switches the port to read mode and issues exactly as many read strobes as the frame count calls for. Finally it switches back to write mode and closes the session with a NOP and a desynchronize command. NOP words sit between commands only to flush the port's internal pipeline.

Words that the port returns with its valid flag are captured into a small credit-managed buffer. They leave on a valid/ready stream in their original order. A single-cycle done pulse marks the end, once the last command word has been written and every captured word has been accepted downstream. All command word values and the starting frame address are parameters.

Top module: `cfg_readback_seq`

## Requirements
- R1: After start the port sees write strobes (port_en=1, port_rd=0) carrying, in this order: SYNC_W, NOP_W, RCFG_W, NOP_W, START_FA (default 0x00000000), then the read header.
- R2: The read header word equals RDHDR_W OR'ed with N in its low bits, where N = 41 × (frames + 1) + 1 and frames is sampled on the start cycle.
- R3: Exactly N read strobes (cycles with port_en=1 and port_rd=1) are issued per sequence.
- R4: After the reads the port sees exactly two more write strobes, NOP_W then DESYNC_W, for eight writes in total.
- R5: port_rd only changes in a cycle where port_en is 0, and every switch between write and read mode includes at least one cycle with port_en low.
- R6: Every word returned with port_rvalid during the read phase appears on out_data exactly once and in order; while out_valid is high and out_ready is low, out_valid stays high and out_data holds.
- R7: done is high for exactly one cycle per sequence, in a cycle where busy is already low; busy is high from the cycle after start until then.
- R8: A start request while busy is ignored: the running sequence completes with its own count and no second sequence follows.
- R9: A synchronous reset, including one during a sequence, returns the block to idle with port_en low, busy low and out_valid low.
- R10: NOP words produce no readback: the number of words delivered on the output stream equals N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled while idle |
| frames | input | FCW | Number of frames to read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| port_en | output | 1 | Configuration port enable, active high |
| port_rd | output | 1 | Port direction: 1 read, 0 write |
| port_wdata | output | 32 | Word written to the port |
| port_rdata | input | 32 | Word returned by the port |
| port_rvalid | input | 1 | port_rdata is valid this cycle |
| out_data | output | 32 | Captured readback word |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Downstream accepts out_data |

## Verification
On every cycle the assertions check the direction-change rule on the port, the hold of data on the output stream under backpressure, the buffer never exceeding its depth, the shape of the done pulse and the quiet idle state after reset. The order and values of the command words, the header count, the exact number of read strobes and the one-to-one, in-order delivery of returned words only show up across whole sequences. The bench's scenarios cover these with several frame counts and ready patterns, a start issued mid-run and a reset issued mid-run.

// File: rtl/cfg_readback_seq.sv
module cfg_readback_seq #(
  parameter int          FCW         = 8,
  parameter int          FRAME_WORDS = 41,
  parameter int          DEPTH       = 8,
  parameter logic [31:0] SYNC_W      = 32'hAA99_5566,
  parameter logic [31:0] NOP_W       = 32'h2000_0000,
  parameter logic [31:0] RCFG_W      = 32'h0000_0004,
  parameter logic [31:0] START_FA    = 32'h0000_0000,
  parameter logic [31:0] RDHDR_W     = 32'h4800_0000,
  parameter logic [31:0] DESYNC_W    = 32'h0000_000D
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [FCW-1:0] frames,
  output logic           busy,
  output logic           done,
  output logic           port_en,
  output logic           port_rd,
  output logic [31:0]    port_wdata,
  input  logic [31:0]    port_rdata,
  input  logic           port_rvalid,
  output logic [31:0]    out_data,
  output logic           out_valid,
  input  logic           out_ready
);

  localparam int NMAX = FRAME_WORDS * (2 ** FCW) + 1;
  localparam int CW   = $clog2(NMAX + 1);
  localparam int AW   = $clog2(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_RD, S_TOWR, S_POST, S_DRAIN} st_t;

  st_t            st;
  logic [2:0]     idx;
  logic [CW-1:0]  nread, left;
  logic [AW:0]    fill, infl;
  logic [AW-1:0]  wp, rp;
  logic [31:0]    mem [DEPTH];

  wire issue = port_en & port_rd;
  wire push  = port_rvalid & (st == S_RD);
  wire pop   = out_valid & out_ready;

  assign busy      = (st != S_IDLE);
  assign out_valid = (fill != '0);
  assign out_data  = mem[rp];

  logic [CW-1:0] left_nx;
  logic [AW:0]   infl_nx;
  logic [AW+1:0] occ;
  logic          en_nx;

  assign left_nx = left - CW'(issue);
  assign infl_nx = infl + (AW+1)'(issue) - (AW+1)'(push);
  assign occ     = (AW+2)'(fill) + (AW+2)'(infl) + (AW+2)'(issue);
  assign en_nx   = (left_nx != '0) && (occ < (AW+2)'(DEPTH));

  function automatic logic [31:0] pre_word(input logic [2:0] i, input logic [CW-1:0] n);
    case (i)
      3'd0:    return SYNC_W;
      3'd1:    return NOP_W;
      3'd2:    return RCFG_W;
      3'd3:    return NOP_W;
      3'd4:    return START_FA;
      default: return RDHDR_W | 32'(n);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= port_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; idx <= '0; nread <= '0; left <= '0;
      infl <= '0; fill <= '0; wp <= '0; rp <= '0;
      port_en <= 1'b0; port_rd <= 1'b0; port_wdata <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      fill <= fill + (AW+1)'(push) - (AW+1)'(pop);
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          nread      <= CW'(FRAME_WORDS) * (CW'(frames) + CW'(1)) + CW'(1);
          idx        <= '0;
          port_en    <= 1'b1;
          port_rd    <= 1'b0;
          port_wdata <= SYNC_W;
          st         <= S_PRE;
        end
        S_PRE: if (idx == 3'd5) begin
          port_en <= 1'b0;
          port_rd <= 1'b1;
          left    <= nread;
          infl    <= '0;
          st      <= S_RD;
        end else begin
          idx        <= idx + 1'b1;
          port_wdata <= pre_word(idx + 1'b1, nread);
        end
        S_RD: begin
          left    <= left_nx;
          infl    <= infl_nx;
          port_en <= en_nx;
          if (left_nx == '0 && infl_nx == '0) begin
            port_en <= 1'b0;
            port_rd <= 1'b0;
            st      <= S_TOWR;
          end
        end
        S_TOWR: begin
          port_en    <= 1'b1;
          port_wdata <= NOP_W;
          idx        <= '0;
          st         <= S_POST;
        end
        S_POST: if (idx == 3'd0) begin
          port_wdata <= DESYNC_W;
          idx        <= 3'd1;
        end else begin
          port_en <= 1'b0;
          st      <= S_DRAIN;
        end
        S_DRAIN: if (fill == '0) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module cfg_readback_seq_chk #(
  parameter int DEPTH = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy,
  input logic                    done,
  input logic                    port_en,
  input logic                    port_rd,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [31:0]             out_data,
  input logic [$clog2(DEPTH):0]  fill
);

  a_r5_rd_moves_en_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_rd) |-> !port_en);

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fill <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !port_en && !out_valid);

  a_r9_reset_to_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy && !port_en);

endmodule

bind cfg_readback_seq cfg_readback_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .port_en(port_en),
  .port_rd(port_rd), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .fill(fill)
);

// File: tb/sim_cfg_readback_seq.sv
module sim_cfg_readback_seq;

  localparam logic [31:0] SYNC   = 32'hAA99_5566;
  localparam logic [31:0] NOP    = 32'h2000_0000;
  localparam logic [31:0] RCFG   = 32'h0000_0004;
  localparam logic [31:0] FA     = 32'h0000_0000;
  localparam logic [31:0] HDR    = 32'h4800_0000;
  localparam logic [31:0] DESYNC = 32'h0000_000D;
  localparam logic [31:0] DBASE  = 32'hA500_0000;

  // {frames, ready pattern}
  localparam int NV = 5;
  localparam logic [9:0] VEC [NV] = '{
    {8'd0, 2'd0}, {8'd1, 2'd1}, {8'd2, 2'd2}, {8'd0, 2'd3}, {8'd3, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  frames = '0;
  logic        busy, done, port_en, port_rd, out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] port_wdata, out_data;
  logic [31:0] port_rdata = '0;
  logic        port_rvalid = 1'b0;

  always #10 clk = ~clk;

  cfg_readback_seq u0 (
    .clk(clk), .rst(rst), .start(start), .frames(frames), .busy(busy), .done(done),
    .port_en(port_en), .port_rd(port_rd), .port_wdata(port_wdata),
    .port_rdata(port_rdata), .port_rvalid(port_rvalid),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  int errors = 0, checks = 0;
  int mode = 0, cyc = 0;
  int wcnt = 0, rdcnt = 0, ocnt = 0, omis = 0, dcnt = 0, swviol = 0;
  logic [31:0] wlog [16];
  logic        p0v = 0, p1v = 0, prd = 0;
  logic [31:0] p0d = '0, p1d = '0;

  // port model: pipelined responder
  always @(negedge clk) begin
    if (rst) begin
      p0v = 0; p1v = 0; port_rvalid = 0; prd = 0;
    end else begin
      if (port_en && !port_rd) begin
        if (wcnt < 16) wlog[wcnt] = port_wdata;
        wcnt++;
      end
      if (port_rd !== prd && port_en) swviol++;
      prd = port_rd;
      port_rvalid = p1v; port_rdata = p1d;
      p1v = p0v; p1d = p0d;
      p0v = port_en && port_rd; p0d = DBASE + 32'(rdcnt);
      if (port_en && port_rd) rdcnt++;
    end
  end

  // stream sink
  always @(negedge clk) begin
    cyc++;
    case (mode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      2: out_ready = (cyc[1:0] == 2'd0);
      default: out_ready = (cyc[5:4] == 2'd0);
    endcase
    if (!rst) begin
      if (out_valid && out_ready) begin
        if (out_data !== DBASE + 32'(ocnt)) omis++;
        ocnt++;
      end
      if (done) dcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input int f, input int m);
    @(posedge clk); #2;
    mode = m; wcnt = 0; rdcnt = 0; ocnt = 0; omis = 0; dcnt = 0; swviol = 0;
    frames = 8'(f); start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 50000 && dcnt == 0; k++) @(posedge clk);
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic verify(input int f);
    int n;
    n = 41 * (f + 1) + 1;
    chk(wlog[0] === SYNC, "R1 word0 sync", wlog[0], SYNC);
    chk(wlog[1] === NOP,  "R1 word1 nop", wlog[1], NOP);
    chk(wlog[2] === RCFG, "R1 word2 rcfg", wlog[2], RCFG);
    chk(wlog[3] === NOP,  "R1 word3 nop", wlog[3], NOP);
    chk(wlog[4] === FA,   "R1 word4 frame addr", wlog[4], FA);
    chk(wlog[5] === (HDR | 32'(n)), "R2 header count", wlog[5], HDR | 32'(n));
    chk(rdcnt == n, "R3 read strobes", 32'(rdcnt), 32'(n));
    chk(wcnt == 8, "R4 write count", 32'(wcnt), 32'd8);
    chk(wlog[6] === NOP,    "R4 trailing nop", wlog[6], NOP);
    chk(wlog[7] === DESYNC, "R4 desync", wlog[7], DESYNC);
    chk(swviol == 0, "R5 rd change while enabled", 32'(swviol), 32'd0);
    chk(omis == 0, "R6 stream order", 32'(omis), 32'd0);
    chk(ocnt == n, "R10 output word count", 32'(ocnt), 32'(n));
    chk(dcnt == 1, "R7 done pulses", 32'(dcnt), 32'd1);
    chk(!busy, "R7 busy after done", 32'(busy), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(!port_en,   "R9 reset port_en", 32'(port_en), 32'd0);
    chk(!busy,      "R9 reset busy", 32'(busy), 32'd0);
    chk(!out_valid, "R9 reset out_valid", 32'(out_valid), 32'd0);
    chk(!done,      "R9 reset done", 32'(done), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      launch(int'(VEC[i][9:2]), int'(VEC[i][1:0]));
      chk(busy, "R7 busy after start", 32'(busy), 32'd1);
      wait_done();
      verify(int'(VEC[i][9:2]));
    end

    // R8: second start while busy is ignored
    launch(1, 0);
    repeat (10) @(posedge clk);
    #2; frames = 8'd5; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    wait_done();
    verify(1);
    repeat (20) @(posedge clk);
    #2;
    chk(wcnt == 8 && !busy, "R8 no second sequence", 32'(wcnt), 32'd8);

    // R9: reset in the middle of the read phase
    launch(2, 2);
    repeat (60) @(posedge clk);
    #2; rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk(!port_en,   "R9 midrun reset port_en", 32'(port_en), 32'd0);
    chk(!busy,      "R9 midrun reset busy", 32'(busy), 32'd0);
    chk(!out_valid, "R9 midrun reset out_valid", 32'(out_valid), 32'd0);
    rst = 1'b0;
    repeat (6) @(posedge clk);
    launch(0, 1);
    wait_done();
    verify(0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule